// File: doc/BRIEF.md
# Speculative Large-Page First-Level TLB

This block is a small, fully associative first-level translation buffer that holds 2MB-granule translations from guest virtual pages to system physical pages. Each entry carries a flag that marks it as speculative. A speculative entry is created when the page walker finds that the guest mapped a large page but the hypervisor backed it with small pages. On a lookup, the guest virtual page number is split into a frame field and an in-frame offset. Only the frame field is compared against the stored tags.

When a flagged entry matches, the block returns a 4KB system physical page that it builds by joining the stored frame with the requested in-frame offset. It reports that page as speculative, so the surrounding logic can start a verification. When an unflagged entry matches, the block returns the same joined page as an ordinary large-page hit. The response is registered and appears one cycle after the lookup. The surrounding logic looks up the 4KB first-level buffer in parallel and also performs the verification.

Entries are loaded through a fill port driven by the walker. They are removed one at a time by frame, or all at once by a flush. When the buffer is full, a tree pseudo-LRU policy chooses the victim.

Top module: `tlbspec_l1_large`

## Requirements
- R1: A lookup presented in cycle N gives `rsp_valid`=1 in cycle N+1. In a cycle after no lookup, `rsp_valid`, `rsp_hit`, `rsp_spec`, `rsp_ppn` and `rsp_paddr` are all zero.
- R2: A lookup matches an entry when guest page bits 35:9 equal the stored tag. Bits 8:0 take no part in the match, and a miss returns hit=0, spec=0 and a page of zero.
- R3: A match on an entry whose speculative flag is clear gives hit=1 and spec=0, with `rsp_ppn` = {stored frame, lookup page bits 8:0}.
- R4: A match on an entry whose speculative flag is set gives hit=1 and spec=1, with `rsp_ppn` built by the same joining rule.
- R5: On a hit, `rsp_paddr` = {`rsp_ppn`, page offset bits 11:0 of the lookup}.
- R6: A fill is classified by its two size flags. Guest large with host large stores a normal entry. Guest large with host small stores a speculative entry. Guest small stores nothing. In both stored cases the data is system page bits 35:9, and bits 8:0 are dropped.
- R7: A fill whose frame is already present overwrites that entry in place. No second entry is allocated.
- R8: An invalidate removes only the entry whose frame matches. If a fill arrives in the same cycle, the invalidate takes effect first.
- R9: A flush clears every entry, and a fill in the same cycle is discarded.
- R10: A new frame goes into the lowest-numbered invalid entry. When no entry is invalid, a tree pseudo-LRU chooses the victim, and both lookup hits and fills update the tree.
- R11: After reset every entry is invalid and all response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 36 | Guest virtual page number to translate |
| lk_pgoff | input | 12 | Byte offset within the 4KB page |
| fill_valid | input | 1 | Fill request from the walker |
| fill_vpn | input | 36 | Guest virtual page number that was walked |
| fill_spp | input | 36 | System physical page number found by the walk |
| fill_guest_large | input | 1 | Guest mapping is a 2MB page |
| fill_host_large | input | 1 | Hypervisor mapping is a 2MB page |
| inv_valid | input | 1 | Invalidate one frame |
| inv_vpn | input | 36 | Page whose 2MB frame is invalidated |
| flush_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Response present (one cycle after lookup) |
| rsp_hit | output | 1 | Lookup matched an entry |
| rsp_spec | output | 1 | Returned page is interpolated and speculative |
| rsp_ppn | output | 36 | System physical page number |
| rsp_paddr | output | 48 | Full system physical address |

## Verification
The assertions assume that the walker never hands over two fills that would leave one frame in two entries. The fill port's overwrite rule keeps this true, so the check of at most one tag match per lookup relies on it. They also assume that `lk_vpn` and `lk_pgoff` are held stable only for the lookup cycle, so each response can be compared against the request of the cycle before. The bench keeps within these assumptions. It drives every request for exactly one cycle on the falling edge, never sends a guest-small fill expecting a stored entry, and issues each flush in a cycle with no lookup.

// File: rtl/tlbspec_pkg.sv
package tlbspec_pkg;
  localparam int VPN_W  = 36;                 // guest / system page number width
  localparam int SUB_W  = 9;                  // 4KB pages inside one 2MB frame
  localparam int PGO_W  = 12;                 // byte offset inside 4KB page
  localparam int TAG_W  = VPN_W - SUB_W;      // 2MB frame number width
  localparam int PA_W   = VPN_W + PGO_W;

  typedef logic [VPN_W-1:0] vpn_t;
  typedef logic [TAG_W-1:0] frame_t;

  // Frame field of a page number (bits 35:9)
  function automatic frame_t frame_of(input vpn_t pn);
    return pn[VPN_W-1:SUB_W];
  endfunction

  // Interpolated page: stored frame joined with the in-frame index
  function automatic vpn_t join_page(input frame_t fr, input vpn_t gvpn);
    return {fr, gvpn[SUB_W-1:0]};
  endfunction

  // Full address: page number joined with byte offset
  function automatic logic [PA_W-1:0] join_addr(input vpn_t pn, input logic [PGO_W-1:0] off);
    return {pn, off};
  endfunction
endpackage

// File: rtl/tlbspec_plru.sv
module tlbspec_plru #(
  parameter int WAYS = 32,
  localparam int IW  = $clog2(WAYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ta_en,
  input  logic [IW-1:0] ta_idx,
  input  logic          tb_en,
  input  logic [IW-1:0] tb_idx,
  output logic [IW-1:0] victim
);
  // Heap-ordered tree; node bit 1 means the LRU side is the upper half
  logic [WAYS-1:1] tree_q, tree_d;

  function automatic logic [WAYS-1:1] touch(input logic [WAYS-1:1] t, input logic [IW-1:0] w);
    logic [WAYS-1:1] r;
    int n;
    r = t;
    n = 1;
    for (int l = 0; l < IW; l++) begin
      r[n] = ~w[IW-1-l];
      n = 2 * n + int'(w[IW-1-l]);
    end
    return r;
  endfunction

  always_comb begin
    tree_d = tree_q;
    if (ta_en) tree_d = touch(tree_d, ta_idx);
    if (tb_en) tree_d = touch(tree_d, tb_idx);
  end

  always_comb begin
    int n;
    n = 1;
    for (int l = 0; l < IW; l++) n = 2 * n + int'(tree_q[n]);
    victim = IW'(n - WAYS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tree_q <= '0;
    else        tree_q <= tree_d;
  end
endmodule

// File: rtl/tlbspec_cam.sv
module tlbspec_cam
  import tlbspec_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               inv_en,
  input  frame_t             inv_tag,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  frame_t             wr_tag,
  input  frame_t             wr_dat,
  input  logic               wr_spec,
  input  frame_t             q_tag,
  input  frame_t             f_tag,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] q_match,
  output logic [ENTRIES-1:0] f_match,
  output frame_t             q_dat,
  output logic               q_spec
);
  frame_t tag_q  [ENTRIES];
  frame_t dat_q  [ENTRIES];
  logic   spec_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic hit_inv;
    assign hit_inv    = valid_vec[i] && (tag_q[i] == inv_tag);
    assign q_match[i] = valid_vec[i] && (tag_q[i] == q_tag);
    assign f_match[i] = valid_vec[i] && (tag_q[i] == f_tag);

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        valid_vec[i] <= 1'b0;
      end else if (wr_en && wr_idx == IW'(i)) begin
        valid_vec[i] <= 1'b1;
        tag_q[i]     <= wr_tag;
        dat_q[i]     <= wr_dat;
        spec_q[i]    <= wr_spec;
      end else if (inv_en && hit_inv) begin
        valid_vec[i] <= 1'b0;
      end
    end
  end

  // At most one match: OR-reduce the selected entry
  always_comb begin
    q_dat  = '0;
    q_spec = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (q_match[i]) begin
        q_dat  = q_dat | dat_q[i];
        q_spec = q_spec | spec_q[i];
      end
    end
  end
endmodule

// File: rtl/tlbspec_l1_large.sv
module tlbspec_l1_large
  import tlbspec_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [35:0]       lk_vpn,
  input  logic [11:0]       lk_pgoff,
  input  logic              fill_valid,
  input  logic [35:0]       fill_vpn,
  input  logic [35:0]       fill_spp,
  input  logic              fill_guest_large,
  input  logic              fill_host_large,
  input  logic              inv_valid,
  input  logic [35:0]       inv_vpn,
  input  logic              flush_all,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_spec,
  output logic [35:0]       rsp_ppn,
  output logic [47:0]       rsp_paddr
);
  logic [ENTRIES-1:0] valid_vec, q_match, f_match;
  frame_t             q_dat;
  logic               q_spec;
  logic               lk_hit;
  logic [IW-1:0]      hit_idx, dup_idx, free_idx, plru_idx, wr_idx;
  logic               have_free, fill_take;
  logic               unused_low;

  assign unused_low = ^{fill_spp[SUB_W-1:0], inv_vpn[SUB_W-1:0]};

  // Only guest-large walks make an entry here
  assign fill_take = fill_valid && fill_guest_large && !flush_all;
  assign lk_hit    = lk_valid && (|q_match);

  always_comb begin
    hit_idx = '0;
    dup_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (q_match[i]) hit_idx = IW'(i);
      if (f_match[i]) dup_idx = IW'(i);
    end
  end

  always_comb begin
    free_idx  = '0;
    have_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx  = IW'(i);
        have_free = 1'b1;
      end
    end
  end

  assign wr_idx = (|f_match) ? dup_idx : (have_free ? free_idx : plru_idx);

  tlbspec_cam #(.ENTRIES(ENTRIES)) u_cam (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_all),
    .inv_en    (inv_valid),
    .inv_tag   (frame_of(inv_vpn)),
    .wr_en     (fill_take),
    .wr_idx    (wr_idx),
    .wr_tag    (frame_of(fill_vpn)),
    .wr_dat    (frame_of(fill_spp)),
    .wr_spec   (!fill_host_large),
    .q_tag     (frame_of(lk_vpn)),
    .f_tag     (frame_of(fill_vpn)),
    .valid_vec (valid_vec),
    .q_match   (q_match),
    .f_match   (f_match),
    .q_dat     (q_dat),
    .q_spec    (q_spec)
  );

  tlbspec_plru #(.WAYS(ENTRIES)) u_plru (
    .clk    (clk),
    .rst_n  (rst_n),
    .ta_en  (lk_hit),
    .ta_idx (hit_idx),
    .tb_en  (fill_take),
    .tb_idx (wr_idx),
    .victim (plru_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_spec  <= 1'b0;
      rsp_ppn   <= '0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_hit;
      rsp_spec  <= lk_hit && q_spec;
      rsp_ppn   <= lk_hit ? join_page(q_dat, lk_vpn) : '0;
      rsp_paddr <= lk_hit ? join_addr(join_page(q_dat, lk_vpn), lk_pgoff) : '0;
    end
  end
endmodule

// File: rtl/tlbspec_l1_large_chk.sv
module tlbspec_l1_large_chk #(
  parameter int ENTRIES = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [35:0]        lk_vpn,
  input logic [11:0]        lk_pgoff,
  input logic               flush_all,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_spec,
  input logic [35:0]        rsp_ppn,
  input logic [47:0]        rsp_paddr,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] q_match
);
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && !rsp_hit && rsp_ppn == '0));
  a_r4_spec_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_spec |-> rsp_hit);
  a_r3_index_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && |q_match) |=> (rsp_ppn[8:0] == $past(lk_vpn[8:0])));
  a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && |q_match) |=> (rsp_paddr == {rsp_ppn, $past(lk_pgoff)}));
  a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_match));
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));
endmodule

bind tlbspec_l1_large tlbspec_l1_large_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .lk_vpn    (lk_vpn),
  .lk_pgoff  (lk_pgoff),
  .flush_all (flush_all),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_spec  (rsp_spec),
  .rsp_ppn   (rsp_ppn),
  .rsp_paddr (rsp_paddr),
  .valid_vec (valid_vec),
  .q_match   (q_match)
);

// File: tb/test_tlbspec_l1_large.sv
`timescale 1ns/1ps
module test_tlbspec_l1_large;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, fill_valid, fill_guest_large, fill_host_large, inv_valid, flush_all;
  logic [35:0] lk_vpn, fill_vpn, fill_spp, inv_vpn;
  logic [11:0] lk_pgoff;
  logic        rsp_valid, rsp_hit, rsp_spec;
  logic [35:0] rsp_ppn;
  logic [47:0] rsp_paddr;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;   // 250 MHz

  tlbspec_l1_large i_tlbspec_l1_large (.*);

  // op: 0 fill, 1 lookup, 2 invalidate
  typedef struct packed {
    logic [1:0]  op;
    logic [35:0] vpn;
    logic [35:0] spp;
    logic        gl;
    logic        hl;
    logic        hit;
    logic        spec;
    logic [35:0] ppn;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 36'h0_0000_0A00, 36'h0_0080_0200, 1'b1, 1'b1, 1'b0, 1'b0, 36'h0},          // R6 normal fill
    '{2'd1, 36'h0_0000_0B23, 36'h0, 1'b0, 1'b0, 1'b1, 1'b0, 36'h0_0080_0323},          // R3
    '{2'd0, 36'h7_0000_0000, 36'h0_00C0_0455, 1'b1, 1'b0, 1'b0, 1'b0, 36'h0},          // R6 spec fill
    '{2'd1, 36'h7_0000_01FF, 36'h0, 1'b0, 1'b0, 1'b1, 1'b1, 36'h0_00C0_05FF},          // R4
    '{2'd1, 36'h7_0000_0000, 36'h0, 1'b0, 1'b0, 1'b1, 1'b1, 36'h0_00C0_0400},          // R4 R2
    '{2'd0, 36'h0_0000_4000, 36'h0_0555_0000, 1'b0, 1'b1, 1'b0, 1'b0, 36'h0},          // R6 guest small
    '{2'd1, 36'h0_0000_4005, 36'h0, 1'b0, 1'b0, 1'b0, 1'b0, 36'h0},                    // R6 not stored
    '{2'd1, 36'h0_0000_0C00, 36'h0, 1'b0, 1'b0, 1'b0, 1'b0, 36'h0},                    // R2 neighbour frame
    '{2'd0, 36'h0_0000_0A55, 36'h0_0090_0000, 1'b1, 1'b0, 1'b0, 1'b0, 36'h0},          // R7 overwrite
    '{2'd1, 36'h0_0000_0A01, 36'h0, 1'b0, 1'b0, 1'b1, 1'b1, 36'h0_0090_0001},          // R7
    '{2'd2, 36'h7_0000_0100, 36'h0, 1'b0, 1'b0, 1'b0, 1'b0, 36'h0},                    // R8
    '{2'd1, 36'h7_0000_0000, 36'h0, 1'b0, 1'b0, 1'b0, 1'b0, 36'h0},                    // R8 gone
    '{2'd1, 36'h0_0000_0A00, 36'h0, 1'b0, 1'b0, 1'b1, 1'b1, 36'h0_0090_0000},          // R8 other kept
    '{2'd2, 36'h0_0000_0A00, 36'h0, 1'b0, 1'b0, 1'b0, 1'b0, 36'h0},                    // R7 no duplicate
    '{2'd1, 36'h0_0000_0A00, 36'h0, 1'b0, 1'b0, 1'b0, 1'b0, 36'h0}                     // R7 no stale copy
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 0; fill_valid = 0; inv_valid = 0; flush_all = 0;
    fill_guest_large = 0; fill_host_large = 0;
    lk_vpn = '0; lk_pgoff = '0; fill_vpn = '0; fill_spp = '0; inv_vpn = '0;
  endtask

  task automatic do_fill(input logic [35:0] v, input logic [35:0] s, input logic gl, input logic hl);
    @(negedge clk);
    fill_valid = 1; fill_vpn = v; fill_spp = s; fill_guest_large = gl; fill_host_large = hl;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_inval(input logic [35:0] v);
    @(negedge clk);
    inv_valid = 1; inv_vpn = v;
    @(negedge clk);
    inv_valid = 0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_all = 1;
    @(negedge clk);
    flush_all = 0;
  endtask

  // Response sampled at the falling edge after the registering edge
  task automatic do_lookup(input logic [35:0] v, input logic [11:0] off, input logic eh,
                           input logic es, input logic [35:0] ep, input string req);
    logic [47:0] ea;
    ea = eh ? {ep, off} : 48'h0;
    @(negedge clk);
    lk_valid = 1; lk_vpn = v; lk_pgoff = off;
    @(negedge clk);
    lk_valid = 0;
    chk(rsp_valid == 1'b1, {req, " R1 valid"}, 64'(rsp_valid), 64'd1);
    chk(rsp_hit == eh, {req, " hit"}, 64'(rsp_hit), 64'(eh));
    chk(rsp_spec == es, {req, " spec"}, 64'(rsp_spec), 64'(es));
    chk(rsp_ppn == (eh ? ep : 36'h0), {req, " ppn"}, 64'(rsp_ppn), 64'(eh ? ep : 36'h0));
    chk(rsp_paddr == ea, {req, " R5 paddr"}, 64'(rsp_paddr), 64'(ea));
  endtask

  function automatic logic [35:0] pvpn(input int i);
    return 36'(i + 'h100) << 9;
  endfunction
  function automatic logic [35:0] pspp(input int i);
    return 36'(i + 'h200) << 9;
  endfunction

  task automatic fill_all_and_touch();
    do_flush();
    for (int i = 0; i < 32; i++) do_fill(pvpn(i), pspp(i), 1'b1, 1'b1);
    for (int i = 0; i < 32; i++) do_lookup(pvpn(i) | 36'h7, 12'h010, 1'b1, 1'b0, pspp(i) | 36'h7, "R10 full");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(!rsp_valid && !rsp_hit && !rsp_spec && rsp_ppn == 0 && rsp_paddr == 0,
        "R11 outputs after reset", 64'({rsp_valid, rsp_hit, rsp_spec}), 64'd0);
    do_lookup(36'h0_0000_0A00, 12'h123, 1'b0, 1'b0, 36'h0, "R11 empty");
    @(negedge clk);
    chk(!rsp_valid && rsp_ppn == 0, "R1 idle cycle", 64'(rsp_valid), 64'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd0: do_fill(VECS[i].vpn, VECS[i].spp, VECS[i].gl, VECS[i].hl);
        2'd2: do_inval(VECS[i].vpn);
        default: do_lookup(VECS[i].vpn, 12'h3C0 + 12'(i), VECS[i].hit, VECS[i].spec,
                           VECS[i].ppn, $sformatf("vec%0d R2 R3 R4 R6 R7 R8", i));
      endcase
    end

    // R9 flush clears and discards a same-cycle fill
    do_fill(36'h0_0000_2000, 36'h0_0001_0000, 1'b1, 1'b1);
    do_lookup(36'h0_0000_2001, 12'h0, 1'b1, 1'b0, 36'h0_0001_0001, "R9 before flush");
    @(negedge clk);
    flush_all = 1; fill_valid = 1; fill_vpn = 36'h0_0000_4200; fill_spp = 36'h0_0002_0000;
    fill_guest_large = 1; fill_host_large = 1;
    @(negedge clk);
    flush_all = 0; fill_valid = 0;
    do_lookup(36'h0_0000_2001, 12'h0, 1'b0, 1'b0, 36'h0, "R9 flushed");
    do_lookup(36'h0_0000_4200, 12'h0, 1'b0, 1'b0, 36'h0, "R9 fill dropped");

    // R8 invalidate and fill in one cycle: fill survives
    @(negedge clk);
    inv_valid = 1; inv_vpn = 36'h0_0000_6000;
    fill_valid = 1; fill_vpn = 36'h0_0000_6000; fill_spp = 36'h0_0003_0000;
    fill_guest_large = 1; fill_host_large = 0;
    @(negedge clk);
    inv_valid = 0; fill_valid = 0;
    do_lookup(36'h0_0000_6003, 12'h0, 1'b1, 1'b1, 36'h0_0003_0003, "R8 fill after inval");

    // R10 invalid-first then tree victim (way 0 after in-order use)
    fill_all_and_touch();
    do_fill(pvpn(64), pspp(64), 1'b1, 1'b1);
    do_lookup(pvpn(0), 12'h0, 1'b0, 1'b0, 36'h0, "R10 victim way0");
    do_lookup(pvpn(1), 12'h0, 1'b1, 1'b0, pspp(1), "R10 way1 kept");
    do_lookup(pvpn(64), 12'h0, 1'b1, 1'b0, pspp(64), "R10 new entry");

    // R10 hit on way 0 moves victim to way 16
    fill_all_and_touch();
    do_lookup(pvpn(0), 12'h0, 1'b1, 1'b0, pspp(0), "R10 touch way0");
    do_fill(pvpn(65), pspp(65), 1'b1, 1'b0);
    do_lookup(pvpn(16), 12'h0, 1'b0, 1'b0, 36'h0, "R10 victim way16");
    do_lookup(pvpn(0), 12'h0, 1'b1, 1'b0, pspp(0), "R10 way0 kept");
    do_lookup(pvpn(65) | 36'h1AB, 12'hFFF, 1'b1, 1'b1, pspp(65) | 36'h1AB, "R10 R4 spec new");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule